// File: doc/BRIEF.md
# Dual-Mode Unrolled Decision Slicer

This block turns the outputs of three receive comparators into data decisions. The comparators sit at an upper threshold, at zero and at a lower threshold. A mode input picks between two signalling schemes. In four-level mode, each unit interval carries one symbol. The three comparator bits form a thermometer code, and the block turns that code into a 2-bit Gray-coded symbol.

In two-level mode, the zero comparator is not used. The upper and lower comparators act as the two pre-sliced outcomes of a one-tap decision-feedback equalizer. The first feedback tap is never subtracted from the signal. The block keeps the previous decision in a register and uses it to pick which of the two pre-sliced results becomes the current bit. The feedback path is therefore one multiplexer, and it settles well within one bit time.

The bit that marks a comparator sample as present (`cmp_valid`) comes once per unit interval. The decision appears one clock later with its own valid bit. When the mode changes, the history is dropped and the first sample taken in the new mode is discarded.

Top module: `dual_mode_dfe_slicer`

## Requirements
- R1: While `rst` is high, and on the first clock after reset, `dec_valid`, `dec_bits` and `therm_err` are 0. The previous-decision register is 0, and the recorded mode is two-level (`mode_pam4`=0).
- R2: A sample accepted with `cmp_valid`=1 at a rising edge produces `dec_valid`=1 after exactly that edge, for exactly one cycle. `dec_valid` is 0 after any edge where `cmp_valid` was 0.
- R3: In four-level mode (`mode_pam4`=1), the code {`cmp_hi`,`cmp_mid`,`cmp_lo`} maps as follows: 000 gives 00, 001 gives 01, 011 gives 11 and 111 gives 10. For these codes `therm_err`=0 and `dec_pam4`=1.
- R4: In four-level mode, the non-thermometer codes 010, 100, 101 and 110 set `therm_err`=1. Each decodes to the level given by its number of ones. So 010 and 100 decode to 01, and 101 and 110 decode to 11.
- R5: In two-level mode, `dec_bits[0]` equals `cmp_hi` when the previous two-level decision was 1. It equals `cmp_lo` when that decision was 0. The new bit becomes the previous decision.
- R6: In two-level mode, `dec_bits[1]`=0, `dec_pam4`=0 and `therm_err`=0, and `cmp_mid` has no effect on the output.
- R7: The first sample accepted after `mode_pam4` differs from the recorded mode is dropped (`dec_valid`=0). This holds whether the change happens on that sample's cycle or on an idle cycle before it. The previous-decision register is cleared to 0 whenever the mode changes.
- R8: The previous decision starts at 0 after reset, so the first two-level bit after reset is taken from `cmp_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_pam4 | input | 1 | 1 = four-level decoding, 0 = two-level unrolled equalizer |
| cmp_valid | input | 1 | Comparator sample present this cycle |
| cmp_hi | input | 1 | Upper-threshold comparator output |
| cmp_mid | input | 1 | Zero-threshold comparator output |
| cmp_lo | input | 1 | Lower-threshold comparator output |
| dec_valid | output | 1 | Registered decision valid |
| dec_bits | output | 2 | Decided symbol (four-level) or {0, bit} (two-level) |
| dec_pam4 | output | 1 | Mode the valid decision was made in |
| therm_err | output | 1 | Non-thermometer comparator code seen |

## Verification
The bench goes after runs in two-level mode where the comparators disagree. A design that wired the history select backwards, or that forgot to store the new decision, would output the wrong comparator in those runs. It also drives all eight comparator codes in four-level mode. A binary mapping in place of Gray would show up as 11 and 10 swapped, and a missing validity check would leave `therm_err` low. Mode changes are applied both on sampled cycles and on idle cycles. A design that failed to drop the first sample, or kept stale history, would emit an extra decision or choose the wrong threshold after returning to two-level mode.

// File: rtl/dfe_slicer_pkg.sv
package dfe_slicer_pkg;
  localparam int CMP_N = 3;
  localparam int SYM_W = 2;
  localparam int CNT_W = $clog2(CMP_N + 1);

  typedef enum logic {
    LANE_NRZ  = 1'b0,
    LANE_PAM4 = 1'b1
  } lane_mode_e;

  function automatic logic [SYM_W-1:0] level_to_gray(input logic [CNT_W-1:0] lvl);
    logic [SYM_W-1:0] b;
    b = SYM_W'(lvl);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/therm_gray_decode.sv
module therm_gray_decode
  import dfe_slicer_pkg::*;
(
  input  logic [CMP_N-1:0] therm,
  output logic [SYM_W-1:0] sym,
  output logic             bad
);
  logic [CNT_W-1:0] ones;
  logic [CMP_N-1:0] ideal;

  always_comb begin
    ones = '0;
    for (int i = 0; i < CMP_N; i++) begin
      ones = ones + CNT_W'(therm[i]);
    end
    ideal = '0;
    for (int i = 0; i < CMP_N; i++) begin
      ideal[i] = (CNT_W'(i) < ones);
    end
    bad = (ideal != therm);
    sym = level_to_gray(ones);
  end
endmodule

// File: rtl/unrolled_tap.sv
module unrolled_tap (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  input  logic slice_up,
  input  logic slice_dn,
  output logic bit_now,
  output logic prev_q
);
  assign bit_now = prev_q ? slice_up : slice_dn;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_q <= 1'b0;
    end else if (advance) begin
      prev_q <= bit_now;
    end
  end
endmodule

// File: rtl/mode_guard.sv
module mode_guard #(
  parameter bit RESET_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_in,
  input  logic sample,
  output logic fresh,
  output logic mode_q
);
  logic pend_q;

  assign fresh = pend_q || (mode_in != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RESET_MODE;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_in;
      pend_q <= fresh && !sample;
    end
  end
endmodule

// File: rtl/dual_mode_dfe_slicer.sv
module dual_mode_dfe_slicer
  import dfe_slicer_pkg::*;
#(
  parameter bit RESET_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pam4,
  input  logic             cmp_valid,
  input  logic             cmp_hi,
  input  logic             cmp_mid,
  input  logic             cmp_lo,
  output logic             dec_valid,
  output logic [SYM_W-1:0] dec_bits,
  output logic             dec_pam4,
  output logic             therm_err
);
  logic             fresh;
  logic             mode_q;
  logic             accept;
  logic             nrz_bit;
  logic             prev_q;
  logic [SYM_W-1:0] pam_sym;
  logic             pam_bad;

  assign accept = cmp_valid && !fresh;

  mode_guard #(.RESET_MODE(RESET_MODE)) guard_i (
    .clk    (clk),
    .rst    (rst),
    .mode_in(mode_pam4),
    .sample (cmp_valid),
    .fresh  (fresh),
    .mode_q (mode_q)
  );

  therm_gray_decode dec_i (
    .therm({cmp_hi, cmp_mid, cmp_lo}),
    .sym  (pam_sym),
    .bad  (pam_bad)
  );

  unrolled_tap tap_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (fresh),
    .advance (accept && (mode_pam4 == LANE_NRZ)),
    .slice_up(cmp_hi),
    .slice_dn(cmp_lo),
    .bit_now (nrz_bit),
    .prev_q  (prev_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_bits  <= '0;
      dec_pam4  <= 1'b0;
      therm_err <= 1'b0;
    end else begin
      dec_valid <= accept;
      therm_err <= 1'b0;
      if (accept) begin
        dec_pam4 <= mode_pam4;
        if (mode_pam4 == LANE_PAM4) begin
          dec_bits  <= pam_sym;
          therm_err <= pam_bad;
        end else begin
          dec_bits <= {{(SYM_W-1){1'b0}}, nrz_bit};
        end
      end
    end
  end
endmodule

// File: rtl/slicer_checker.sv
module slicer_checker (
  input logic       clk,
  input logic       rst,
  input logic       mode_pam4,
  input logic       cmp_valid,
  input logic       cmp_hi,
  input logic       cmp_mid,
  input logic       cmp_lo,
  input logic       fresh,
  input logic       prev_q,
  input logic       dec_valid,
  input logic [1:0] dec_bits,
  input logic       dec_pam4,
  input logic       therm_err
);
  a_r2_valid_from_sample: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(cmp_valid));

  a_r3_top_level_gray: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && mode_pam4 && !fresh && cmp_hi && cmp_mid && cmp_lo)
      |=> (dec_bits == 2'b10 && !therm_err && dec_valid));

  a_r5_hist_one_upper: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !mode_pam4 && !fresh && prev_q)
      |=> (dec_bits == {1'b0, $past(cmp_hi)}));

  a_r5_hist_zero_lower: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !mode_pam4 && !fresh && !prev_q)
      |=> (dec_bits == {1'b0, $past(cmp_lo)}));

  a_r6_nrz_no_err: assert property (@(posedge clk) disable iff (rst)
    therm_err |-> (dec_valid && dec_pam4));

  a_r7_switch_drops: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && fresh) |=> (!dec_valid && !prev_q));
endmodule

bind dual_mode_dfe_slicer slicer_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_pam4(mode_pam4),
  .cmp_valid(cmp_valid),
  .cmp_hi   (cmp_hi),
  .cmp_mid  (cmp_mid),
  .cmp_lo   (cmp_lo),
  .fresh    (fresh),
  .prev_q   (prev_q),
  .dec_valid(dec_valid),
  .dec_bits (dec_bits),
  .dec_pam4 (dec_pam4),
  .therm_err(therm_err)
);

// File: tb/dual_mode_dfe_slicer_tb_top.sv
module dual_mode_dfe_slicer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_pam4 = 1'b0;
  logic cmp_valid = 1'b0;
  logic cmp_hi = 1'b0, cmp_mid = 1'b0, cmp_lo = 1'b0;
  logic dec_valid;
  logic [1:0] dec_bits;
  logic dec_pam4;
  logic therm_err;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_mode = 0;
  int m_pend = 0;
  int m_prev = 0;
  int e_valid, e_bits, e_pam4, e_err;
  string e_req;

  always #4 clk = ~clk;

  dual_mode_dfe_slicer dut_i (
    .clk(clk), .rst(rst), .mode_pam4(mode_pam4), .cmp_valid(cmp_valid),
    .cmp_hi(cmp_hi), .cmp_mid(cmp_mid), .cmp_lo(cmp_lo),
    .dec_valid(dec_valid), .dec_bits(dec_bits), .dec_pam4(dec_pam4),
    .therm_err(therm_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock with the given inputs, model advanced and outputs compared
  task automatic step(input int v, input int m, input int h, input int mi, input int l);
    int fresh, code, ones;
    mode_pam4 = m[0]; cmp_valid = v[0];
    cmp_hi = h[0]; cmp_mid = mi[0]; cmp_lo = l[0];
    fresh = (m_pend != 0 || m != m_mode) ? 1 : 0;
    e_valid = (v != 0 && fresh == 0) ? 1 : 0;
    e_err = 0;
    e_req = "R2";
    if (e_valid != 0) begin
      if (m != 0) begin
        code = h * 4 + mi * 2 + l;
        ones = h + mi + l;
        case (ones)
          0: e_bits = 0;
          1: e_bits = 1;
          2: e_bits = 3;
          default: e_bits = 2;
        endcase
        e_err = (code == 0 || code == 1 || code == 3 || code == 7) ? 0 : 1;
        e_pam4 = 1;
        e_req = (e_err != 0) ? "R4" : "R3";
      end else begin
        e_bits = (m_prev != 0) ? h : l;
        m_prev = e_bits;
        e_pam4 = 0;
        e_req = "R5";
      end
    end else if (v != 0) begin
      e_req = "R7";
    end
    if (fresh != 0) m_prev = 0;
    m_pend = (fresh != 0 && v == 0) ? 1 : 0;
    m_mode = m;
    @(posedge clk);
    @(negedge clk);
    check({e_req, " valid"}, int'(dec_valid), e_valid);
    if (e_valid != 0) begin
      check({e_req, " bits"}, int'(dec_bits), e_bits);
      check({e_req, " mode R6"}, int'(dec_pam4), e_pam4);
      check({e_req, " err"}, int'(therm_err), e_err);
    end else begin
      check("R2 err idle", int'(therm_err), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid in reset", int'(dec_valid), 0);
    check("R1 bits in reset", int'(dec_bits), 0);
    check("R1 err in reset", int'(therm_err), 0);
    rst = 1'b0;
    // R8: first bit after reset uses lower comparator
    step(1, 0, 0, 1, 1);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 1);
    // R5/R6: comparators disagree, mid toggled with no effect
    step(1, 0, 1, 0, 0);  // prev 0 -> lo=0
    step(1, 0, 1, 1, 1);  // prev 0 -> 1
    step(1, 0, 0, 1, 1);  // prev 1 -> hi=0
    step(1, 0, 1, 0, 0);  // prev 0 -> lo=0
    step(1, 0, 0, 0, 1);  // prev 0 -> 1
    step(1, 0, 1, 1, 0);  // prev 1 -> hi=1
    step(1, 0, 1, 0, 0);  // prev 1 -> 1
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      step(int'(lfsr[7] | lfsr[3]), 0, int'(lfsr[0]), int'(lfsr[4]), int'(lfsr[1]));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // R7: switch to four-level on a sampled cycle
    step(1, 0, 1, 1, 1);
    step(1, 1, 1, 1, 1);
    for (int c = 0; c < 8; c++) step(1, 1, (c >> 2) & 1, (c >> 1) & 1, c & 1);
    step(0, 1, 0, 0, 0);
    // R7: switch back on an idle cycle, then sample
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0);   // dropped
    step(1, 0, 1, 0, 0);   // prev cleared -> lo=0
    step(1, 0, 0, 0, 1);
    step(1, 0, 1, 0, 0);
    // quick toggles
    step(1, 1, 0, 1, 1);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(1, 1, 0, 1, 0);
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < 30; i++) begin
      step(int'(lfsr[2] | lfsr[6]), 1, int'(lfsr[0]), int'(lfsr[3]), int'(lfsr[5]));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // R1: reset mid-stream
    rst = 1'b1; m_mode = 0; m_pend = 0; m_prev = 0;
    mode_pam4 = 1'b0; cmp_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 valid after reset", int'(dec_valid), 0);
    rst = 1'b0;
    step(1, 0, 1, 0, 1);
    step(1, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule